// File: doc/BRIEF.md
# Aging Reference History Tracker

This block picks which page frame to evict using an aging approximation of least-recently-used order. Each of a set of page frames keeps a one-bit "referenced" flag and an 8-bit history register. A memory access to a frame raises that frame's flag. A periodic tick shifts every history one place toward the low end, and the frame's flag fills the vacated top bit. The flag is then cleared for the next interval. A frame touched in recent intervals therefore carries a large history value, and a frame that has been idle for a long time decays toward zero.

When the page-fault logic asks for a victim, the block compares every history as an unsigned number in a balanced comparison tree. It returns the frame index with the smallest value, together with that value, after a fixed one-cycle latency. Ties go to the lowest frame index. The number of frames is a parameter. Frame counts that are not a power of two are padded inside the tree, and these padded slots can never win. Producing the tick and loading pages are the job of the surrounding logic.

Top module: `aging_tracker`

## Requirements
- R1: After reset, every history and every referenced flag is zero, `victim_valid` is low, and a victim request returns frame 0 with history 0.
- R2: An access with `access_valid` high to frame f, with `tick` low in that cycle, sets the referenced flag of frame f. The flag stays set until the next tick.
- R3: On a cycle with `tick` high, each frame's history becomes {flag, history[7:1]}: the old flag enters bit 7 and the old bit 0 is lost. Without a tick, histories do not change.
- R4: A tick clears every referenced flag. An access arriving in the tick cycle sets its frame's flag for the following interval.
- R5: `victim_valid` is high in the cycle after a cycle with `victim_req` high, and low otherwise. `victim_frame` and `victim_hist` then reflect the histories as they were before that clock edge, which means before any tick on the same edge.
- R6: The reported frame has the smallest history, compared as an unsigned 8-bit number, among frames 0 to NUM_FRAMES-1.
- R7: When several frames share the smallest history, the lowest frame index is reported.
- R8: An access whose `access_frame` is NUM_FRAMES or greater has no effect on any frame, and such an index is never reported as a victim.
- R9: `victim_hist` equals the history of the reported frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| access_valid | input | 1 | A memory access hits a frame this cycle |
| access_frame | input | IDX_W | Frame index of the access |
| tick | input | 1 | Aging interval boundary |
| victim_req | input | 1 | Request a replacement choice |
| victim_valid | output | 1 | Victim result valid (one cycle after request) |
| victim_frame | output | IDX_W | Index of the chosen frame |
| victim_hist | output | 8 | History value of the chosen frame |

## Verification
The bench builds the block with six frames. This leaves a 3-bit index with two unused codes and a comparison tree padded from six leaves to eight. Random accesses to indices 6 and 7 therefore test whether out-of-range frames are ignored, and they check that padded leaves never win. Directed sequences cover all-zero ties after reset, an access that lands on a tick edge, and requests issued on the same edge as a tick. Long random runs push histories through all eight bit positions and beyond, so that bits are seen falling off the low end.

// File: rtl/aging_pkg.sv
package aging_pkg;
  localparam int unsigned AGE_W = 8;
  typedef logic [AGE_W-1:0] age_t;
endpackage

// File: rtl/age_frame_slot.sv
module age_frame_slot
  import aging_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic tick,
  output age_t hist
);
  logic ref_q, ref_nxt;
  age_t hist_nxt;
  logic ref_en, hist_en;

  always_comb begin
    ref_en   = tick | hit;
    ref_nxt  = hit;
    hist_en  = tick;
    hist_nxt = {ref_q, hist[AGE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      hist  <= '0;
    end else begin
      if (ref_en)  ref_q <= ref_nxt;
      if (hist_en) hist  <= hist_nxt;
    end
  end

  p_ref_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !tick) |=> ref_q);
  p_shift_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (hist[AGE_W-2:0] == $past(hist[AGE_W-1:1])));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hist));
  p_tick_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit) |=> !ref_q);
endmodule

// File: rtl/age_cmp_node.sv
module age_cmp_node
  import aging_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             a_ok,
  input  age_t             a_age,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_ok,
  input  age_t             b_age,
  input  logic [IDX_W-1:0] b_idx,
  output logic             y_ok,
  output age_t             y_age,
  output logic [IDX_W-1:0] y_idx
);
  logic take_a;
  always_comb begin
    take_a = a_ok && (!b_ok || (a_age <= b_age));
    y_ok   = a_ok | b_ok;
    y_age  = take_a ? a_age : b_age;
    y_idx  = take_a ? a_idx : b_idx;
  end
endmodule

// File: rtl/age_min_tree.sv
module age_min_tree
  import aging_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 8,
  parameter int unsigned IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_FRAMES*AGE_W-1:0] hist_flat,
  input  logic                        req,
  output logic                        res_valid,
  output logic [IDX_W-1:0]            res_idx,
  output age_t                        res_age
);
  localparam int unsigned LEVELS = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam int unsigned PADN   = 1 << LEVELS;
  localparam int unsigned NODES  = 2 * PADN - 1;

  logic             n_ok  [NODES];
  age_t             n_age [NODES];
  logic [IDX_W-1:0] n_idx [NODES];

  for (genvar i = 0; i < PADN; i++) begin : g_leaf
    if (i < NUM_FRAMES) begin : g_real
      assign n_ok [PADN-1+i] = 1'b1;
      assign n_age[PADN-1+i] = hist_flat[i*AGE_W +: AGE_W];
      assign n_idx[PADN-1+i] = IDX_W'(i);
    end else begin : g_pad
      assign n_ok [PADN-1+i] = 1'b0;
      assign n_age[PADN-1+i] = '1;
      assign n_idx[PADN-1+i] = '0;
    end
  end

  for (genvar k = 0; k < PADN - 1; k++) begin : g_node
    age_cmp_node #(.IDX_W(IDX_W)) u_node (
      .a_ok (n_ok [2*k+1]), .a_age(n_age[2*k+1]), .a_idx(n_idx[2*k+1]),
      .b_ok (n_ok [2*k+2]), .b_age(n_age[2*k+2]), .b_idx(n_idx[2*k+2]),
      .y_ok (n_ok [k]),     .y_age(n_age[k]),     .y_idx(n_idx[k])
    );
  end

  logic             valid_nxt;
  logic [IDX_W-1:0] idx_nxt;
  age_t             age_nxt;

  always_comb begin
    valid_nxt = req;
    idx_nxt   = n_idx[0];
    age_nxt   = n_age[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_idx   <= '0;
      res_age   <= '0;
    end else begin
      res_valid <= valid_nxt;
      if (req) begin
        res_idx <= idx_nxt;
        res_age <= age_nxt;
      end
    end
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> res_valid);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !res_valid);
  p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (32'(res_idx) < NUM_FRAMES));
  p_hold_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(res_idx) && $stable(res_age)));
endmodule

// File: rtl/aging_tracker.sv
module aging_tracker
  import aging_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 8,
  localparam int unsigned IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_valid,
  input  logic [IDX_W-1:0] access_frame,
  input  logic             tick,
  input  logic             victim_req,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_frame,
  output logic [AGE_W-1:0] victim_hist
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NUM_FRAMES-1:0]       hit;
  logic [NUM_FRAMES*AGE_W-1:0] hist_flat;

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_slot
    age_t h;
    assign hit[i] = access_valid && (access_frame == IDX_W'(i));
    age_frame_slot u_slot (
      .clk  (clk),
      .rst_n(rst_int_n),
      .hit  (hit[i]),
      .tick (tick),
      .hist (h)
    );
    assign hist_flat[i*AGE_W +: AGE_W] = h;
  end

  age_min_tree #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_tree (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hist_flat(hist_flat),
    .req      (victim_req),
    .res_valid(victim_valid),
    .res_idx  (victim_frame),
    .res_age  (victim_hist)
  );

  p_onehot_hit_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(hit));
  p_oob_ignored_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (access_valid && (32'(access_frame) >= NUM_FRAMES)) |-> (hit == '0));
endmodule

// File: tb/aging_tracker_bench.sv
module aging_tracker_bench;
  localparam int N  = 6;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic access_valid = 1'b0;
  logic [IW-1:0] access_frame = '0;
  logic tick = 1'b0;
  logic victim_req = 1'b0;
  logic victim_valid;
  logic [IW-1:0] victim_frame;
  logic [7:0] victim_hist;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_hist [N];
  logic       m_ref  [N];

  always #4 clk = ~clk;

  aging_tracker #(.NUM_FRAMES(N)) u_aging_tracker (
    .clk(clk), .rst_n(rst_n), .access_valid(access_valid),
    .access_frame(access_frame), .tick(tick), .victim_req(victim_req),
    .victim_valid(victim_valid), .victim_frame(victim_frame),
    .victim_hist(victim_hist)
  );

  function automatic int model_min_idx();
    int best = 0;
    for (int i = 1; i < N; i++) if (m_hist[i] < m_hist[best]) best = i;
    return best;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; applies inputs for one cycle, checks at next negedge
  task automatic step(input bit av, input int af, input bit tk, input bit rq,
                      input string tag);
    int ei;
    logic [7:0] eh;
    access_valid = av; access_frame = IW'(af); tick = tk; victim_req = rq;
    ei = model_min_idx();
    eh = m_hist[ei];
    for (int i = 0; i < N; i++) begin
      if (tk) begin
        m_hist[i] = {m_ref[i], m_hist[i][7:1]};
        m_ref[i]  = av && (af == i);
      end else if (av && af == i) begin
        m_ref[i] = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " R5 valid"}, int'(victim_valid), int'(rq));
    if (rq) begin
      check({tag, " frame"}, int'(victim_frame), ei);
      check({tag, " R9 hist"}, int'(victim_hist), int'(eh));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_hist[i] = '0; m_ref[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset valid", int'(victim_valid), 0);
    step(0, 0, 0, 1, "R1 R7 all-zero tie");
    // R2 R6 R7: frames 0 and 2 referenced, frame 1 lowest zero
    step(1, 0, 0, 0, "R2");
    step(1, 2, 0, 0, "R2");
    step(0, 0, 1, 1, "R5 req on tick edge");
    step(0, 0, 0, 1, "R3 R6 R7 min after shift");
    // R8: out-of-range accesses ignored
    step(1, 6, 0, 0, "R8");
    step(1, 7, 0, 0, "R8");
    step(0, 0, 1, 0, "R8");
    step(0, 0, 0, 1, "R8 R6 oob ignored");
    // R4: access on tick edge counts for the next interval
    for (int f = 0; f < N; f++) if (f != 3) step(1, f, 0, 0, "R4 prep");
    step(1, 3, 1, 0, "R4 tick with access");
    step(0, 0, 1, 0, "R4 second tick");
    step(0, 0, 0, 1, "R4 R7 victim");
    // R3: histories decay past bit 0
    repeat (9) step(0, 0, 1, 0, "R3 decay");
    step(0, 0, 0, 1, "R3 R7 fully decayed");
    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 2) == 0, int'($urandom % 8), ($urandom % 4) == 0,
           ($urandom % 3) == 0, "R6 random");
    end
    step(0, 0, 0, 0, "R5 idle");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule